// File: doc/BRIEF.md
# Spike-Gated Pointer Fan-Out

This block takes one wide read word per strobe and spreads it across sixteen lane FIFOs. Each 32-bit lane of the word is a pointer record: a 9-bit synapse-list length above a 23-bit start address. A lane is written only when its neuron group fired in the spike mask of the sub-phase that is running. The sub-phase is held by a small tracker. A start pulse moves it into external-event reading. An external-done pulse moves it on to internal-event reading, and an internal-done pulse returns it to idle.

The lane FIFOs sit outside the block and report only their full flags. A pointer aimed at a full lane is thrown away, with no stall and no retry. A sticky per-lane drop flag records each such loss until the next start pulse or reset. Every strobed word is also consumed from the upstream first-word-fall-through buffer, whether or not any lane takes it.

Top module: `spf_top`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is held, and in the first cycle after it, the phase is idle (both phase outputs 0), every drop flag is 0 and no lane write enable is asserted, whatever the other inputs are.
- R2: Lane i of `lane_din_o` is bits [32*i+31:32*i] of `word_i`, passed on unchanged: length in bits [31:23] and start address in bits [22:0] of the lane.
- R3: A start pulse puts the tracker into external reading (`ext_phase_o`=1, `int_phase_o`=0) on the next cycle from any phase. It wins over both done pulses in the same cycle.
- R4: With no start pulse, an external-done pulse while the phase is not internal reading moves the tracker to internal reading on the next cycle. This applies from idle as well as from external reading.
- R5: With neither of the above, an internal-done pulse while internal reading returns the tracker to idle on the next cycle. An internal-done pulse in any other phase is ignored, and an external-done pulse during internal reading is ignored.
- R6: `ext_phase_o` and `int_phase_o` are never 1 together.
- R7: `lane_wr_o[i]` is 1 exactly when `word_vld_i` is 1, `lane_full_i[i]` is 0, and either the phase is external reading with `ext_mask_i[i]`=1 or the phase is internal reading with `int_mask_i[i]`=1. The phase in question is the phase registered at the start of that cycle.
- R8: A lane that would be written but is full gets no write. The other lanes and `word_adv_o` act in that cycle as if the full lane were not involved.
- R9: `word_adv_o` equals `word_vld_i` in every cycle.
- R10: `lane_drop_o[i]` goes to 1 in the cycle after a pointer for lane i is discarded under R8, and then stays 1. It returns to 0 in the cycle after a start pulse, and a start pulse wins over a discard in the same cycle. Reset also clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that begins a time step |
| ext_done_i | input | 1 | External-event reading finished |
| int_done_i | input | 1 | Internal-event reading finished |
| ext_mask_i | input | 16 | Spike mask for external reading, one bit per lane |
| int_mask_i | input | 16 | Spike mask for internal reading, one bit per lane |
| word_vld_i | input | 1 | Read word valid and consumed this cycle |
| word_i | input | 512 | Read word of sixteen pointer records |
| lane_full_i | input | 16 | Full flag of each lane FIFO |
| lane_wr_o | output | 16 | Write enable of each lane FIFO |
| lane_din_o | output | 512 | Write data of the lane FIFOs, 32 bits per lane |
| word_adv_o | output | 1 | Read-advance strobe to the upstream word buffer |
| ext_phase_o | output | 1 | Tracker is in external reading |
| int_phase_o | output | 1 | Tracker is in internal reading |
| lane_drop_o | output | 16 | Sticky per-lane discard flag |

## Verification
Directed sequences first drive single-bit, multi-bit, empty and all-ones spike masks through each phase. These show whether the right mask is picked for the active phase and whether lanes stay apart. Later sequences pulse start, external-done and internal-done together in every phase, and drive a mask change on the same edge as a phase change. These expose any error in priority or in which phase a write is qualified by. Full flags on chosen lanes, including a discard in the same cycle as a start pulse, separate silent dropping from stalling and check the clearing order of the drop flags. A long pseudo-random stretch with sparse pulses and random masks, full flags and strobes is then compared with the bench model on every clock.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int LANES  = 16;
    localparam int LEN_W  = 9;
    localparam int ADDR_W = 23;
    localparam int PTR_W  = LEN_W + ADDR_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EXT  = 2'd1,
        PH_INT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } ptr_rec_t;

    // Priority: start, then external-done (unless internal), then internal-done.
    function automatic phase_e next_phase(phase_e cur, logic go, logic ext_fin, logic int_fin);
        phase_e nxt;
        nxt = cur;
        if (go)
            nxt = PH_EXT;
        else if (ext_fin && cur != PH_INT)
            nxt = PH_INT;
        else if (int_fin && cur == PH_INT)
            nxt = PH_IDLE;
        return nxt;
    endfunction

endpackage

// File: rtl/spf_phase_ctl.sv
module spf_phase_ctl
    import spf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   ext_done_i,
    input  logic   int_done_i,
    output phase_e phase_o,
    output logic   ext_o,
    output logic   int_o
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_IDLE;
        else
            phase_q <= next_phase(phase_q, start_i, ext_done_i, int_done_i);
    end

    assign phase_o = phase_q;
    assign ext_o   = (phase_q == PH_EXT);
    assign int_o   = (phase_q == PH_INT);

    // R3: start always lands in external reading
    a_r3_start_to_ext: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (ext_o && !int_o));

    // R4: external-done advances to internal reading
    a_r4_ext_done_advance: assert property (@(posedge clk) disable iff (rst)
        (!start_i && ext_done_i && !int_o) |=> (int_o && !ext_o));

    // R5: internal-done ends internal reading
    a_r5_int_done_idle: assert property (@(posedge clk) disable iff (rst)
        (!start_i && int_done_i && int_o) |=> (!int_o && !ext_o));

    // R5: internal-done outside internal reading leaves the phase alone
    a_r5_int_done_ignored: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !ext_done_i && !int_o) |=> $stable(phase_o));

endmodule

// File: rtl/spf_lane_gate.sv
module spf_lane_gate
    import spf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic ext_ph_i,
    input  logic int_ph_i,
    input  logic ext_bit_i,
    input  logic int_bit_i,
    input  logic vld_i,
    input  logic full_i,
    output logic wr_o,
    output logic drop_o
);

    logic sel;
    logic hit;
    logic drop_q;

    assign sel  = (ext_ph_i & ext_bit_i) | (int_ph_i & int_bit_i);
    assign hit  = vld_i & sel;
    assign wr_o = hit & ~full_i;

    always_ff @(posedge clk) begin
        if (rst)
            drop_q <= 1'b0;
        else if (start_i)
            drop_q <= 1'b0;
        else if (hit && full_i)
            drop_q <= 1'b1;
    end

    assign drop_o = drop_q;

    // R8: a full lane is never written
    a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        full_i |-> !wr_o);

    // R10: a discarded pointer raises the flag
    a_r10_drop_sets: assert property (@(posedge clk) disable iff (rst)
        (!start_i && vld_i && full_i && sel) |=> drop_o);

    // R10: the flag holds until a start pulse
    a_r10_drop_holds: assert property (@(posedge clk) disable iff (rst)
        (drop_o && !start_i) |=> drop_o);

    // R10: start clears, even over a same-cycle discard
    a_r10_drop_clears: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !drop_o);

endmodule

// File: rtl/spf_top.sv
module spf_top
    import spf_pkg::*;
#(
    parameter int NLANE = spf_pkg::LANES,
    localparam int WORD_W = NLANE * PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ext_done_i,
    input  logic              int_done_i,
    input  logic [NLANE-1:0]  ext_mask_i,
    input  logic [NLANE-1:0]  int_mask_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [NLANE-1:0]  lane_full_i,
    output logic [NLANE-1:0]  lane_wr_o,
    output logic [WORD_W-1:0] lane_din_o,
    output logic              word_adv_o,
    output logic              ext_phase_o,
    output logic              int_phase_o,
    output logic [NLANE-1:0]  lane_drop_o
);

    phase_e phase;
    logic   ext_ph;
    logic   int_ph;

    spf_phase_ctl u_phase (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .ext_done_i (ext_done_i),
        .int_done_i (int_done_i),
        .phase_o    (phase),
        .ext_o      (ext_ph),
        .int_o      (int_ph)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        ptr_rec_t rec;
        assign rec = ptr_rec_t'(word_i[g*PTR_W +: PTR_W]);
        assign lane_din_o[g*PTR_W +: PTR_W] = rec;

        spf_lane_gate u_gate (
            .clk       (clk),
            .rst       (rst),
            .start_i   (start_i),
            .ext_ph_i  (ext_ph),
            .int_ph_i  (int_ph),
            .ext_bit_i (ext_mask_i[g]),
            .int_bit_i (int_mask_i[g]),
            .vld_i     (word_vld_i),
            .full_i    (lane_full_i[g]),
            .wr_o      (lane_wr_o[g]),
            .drop_o    (lane_drop_o[g])
        );
    end

    assign word_adv_o  = word_vld_i;
    assign ext_phase_o = ext_ph;
    assign int_phase_o = int_ph;

    // R6: the two phase outputs are exclusive
    a_r6_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ext_phase_o && int_phase_o));

    // R7: no lane writes while idle
    a_r7_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (lane_wr_o == '0));

    // R7: no lane writes without a strobe
    a_r7_strobe_needed: assert property (@(posedge clk) disable iff (rst)
        !word_vld_i |-> (lane_wr_o == '0));

endmodule

// File: tb/spf_top_tb_top.sv
`timescale 1ns/1ps
module spf_top_tb_top;

    localparam int NL = 16;
    localparam int WW = NL * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0, ext_done_i = 1'b0, int_done_i = 1'b0;
    logic [NL-1:0] ext_mask_i = '0, int_mask_i = '0, lane_full_i = '0;
    logic          word_vld_i = 1'b0;
    logic [WW-1:0] word_i = '0;
    logic [NL-1:0] lane_wr_o, lane_drop_o;
    logic [WW-1:0] lane_din_o;
    logic          word_adv_o, ext_phase_o, int_phase_o;

    spf_top dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .ext_done_i(ext_done_i),
        .int_done_i(int_done_i), .ext_mask_i(ext_mask_i), .int_mask_i(int_mask_i),
        .word_vld_i(word_vld_i), .word_i(word_i), .lane_full_i(lane_full_i),
        .lane_wr_o(lane_wr_o), .lane_din_o(lane_din_o), .word_adv_o(word_adv_o),
        .ext_phase_o(ext_phase_o), .int_phase_o(int_phase_o), .lane_drop_o(lane_drop_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // reference model state: 0 idle, 1 external, 2 internal
    int            m_ph = 0;
    logic [NL-1:0] m_drop = '0;
    string         ph_tag = "R1";

    task automatic chk(input string tag, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_i = 1'b0; ext_done_i = 1'b0; int_done_i = 1'b0;
        ext_mask_i = '1; int_mask_i = '1; word_vld_i = 1'b1; lane_full_i = '1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
        // R1: state while reset is still held
        chk("R1", "phase in reset", {ext_phase_o, int_phase_o}, 2'b00);
        chk("R1", "drop in reset", lane_drop_o, '0);
        chk("R1", "write in reset", lane_wr_o, '0);
        rst = 1'b0;
        m_ph = 0; m_drop = '0; ph_tag = "R1";
    endtask

    task automatic step(input logic st, input logic ed, input logic idn,
                        input logic [NL-1:0] em, input logic [NL-1:0] im,
                        input logic v, input logic [NL-1:0] fl);
        logic [31:0]   vals[NL];
        logic [WW-1:0] w;
        logic [NL-1:0] want, exp_wr, exp_lost;
        string         wtag;
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            vals[i] = $urandom;
            w[i*32 +: 32] = vals[i];
        end
        start_i = st; ext_done_i = ed; int_done_i = idn;
        ext_mask_i = em; int_mask_i = im; word_vld_i = v; lane_full_i = fl;
        word_i = w;
        #1;
        for (int i = 0; i < NL; i++)
            want[i] = v && ((m_ph == 1 && em[i]) || (m_ph == 2 && im[i]));
        exp_wr   = want & ~fl;
        exp_lost = want & fl;
        wtag = (exp_lost != '0) ? "R8" : "R7";
        chk(ph_tag, "ext_phase", ext_phase_o, (m_ph == 1));
        chk(ph_tag, "int_phase", int_phase_o, (m_ph == 2));
        chk("R6", "phases exclusive", ext_phase_o & int_phase_o, 1'b0);
        chk(wtag, "lane_wr", lane_wr_o, exp_wr);
        chk("R2", "lane_din", lane_din_o, w);
        chk("R2", "lane 15 length", lane_din_o[511:503], vals[15][31:23]);
        chk("R9", "word_adv", word_adv_o, v);
        chk("R10", "lane_drop", lane_drop_o, m_drop);
        // model update for the coming edge
        if (st) begin
            m_ph = 1; ph_tag = "R3";
        end else if (ed && m_ph != 2) begin
            m_ph = 2; ph_tag = "R4";
        end else if (idn) begin
            if (m_ph == 2) m_ph = 0;
            ph_tag = "R5";
        end else begin
            ph_tag = "R6";
        end
        m_drop = st ? '0 : (m_drop | exp_lost);
        @(posedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish act=hung exp=done");
        summary();
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: first cycle after reset, strobe with all masks set
        step(0, 0, 0, '1, '1, 1, '0);
        // R3 start, then R7 writes under external masks
        step(1, 0, 0, '0, '0, 0, '0);
        step(0, 0, 0, 16'h0005, 16'hFFFF, 1, '0);
        step(0, 0, 0, 16'h0003, 16'h0000, 1, '0);
        step(0, 0, 0, 16'h0000, 16'hFFFF, 1, '0);
        step(0, 0, 0, 16'h8000, 16'h0000, 0, '0);
        // R4 with a strobe on the boundary: old phase qualifies
        step(0, 1, 0, 16'hFFFF, 16'h0001, 1, '0);
        // R7/R8 internal masks with lane 7 full
        step(0, 0, 0, 16'hFFFF, 16'h0089, 1, 16'h0080);
        step(0, 0, 0, 16'h0000, 16'h0089, 1, 16'h0000);
        // R5 with external-done ignored in internal reading
        step(0, 1, 1, 16'h0000, 16'hFFFF, 1, '0);
        step(0, 0, 1, '1, '1, 1, '0);
        // R4 from idle
        step(0, 1, 0, '1, '1, 1, '0);
        // R10 start wins over a same-cycle discard
        step(1, 0, 0, 16'h0000, 16'h0010, 1, 16'h0010);
        step(0, 0, 1, 16'h0010, 16'h0000, 1, '0);
        // R3 priority over both done pulses
        step(1, 1, 1, '0, '0, 0, '0);
        // R8 every lane full in external reading
        step(0, 0, 0, '1, '0, 1, '1);
        step(0, 0, 0, '1, '0, 1, 16'h00FF);
        step(0, 0, 0, '0, '0, 0, '0);
        // R1 mid-run reset clears drops
        do_reset();
        step(0, 0, 0, '1, '1, 1, '1);
        // long mixed stretch
        for (int n = 0; n < 4000; n++) begin
            step(($urandom_range(39) == 0), ($urandom_range(29) == 0),
                 ($urandom_range(29) == 0), 16'($urandom), 16'($urandom),
                 ($urandom_range(1) == 1), 16'($urandom & $urandom & $urandom));
        end
        summary();
        $finish;
    end

endmodule